// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry input with no clock. The operands are split into four 4-bit slices. Each slice forms a generate term (a AND b) and a propagate term (a OR b) for every bit. From these it derives the carries inside the slice, and also a slice-wide propagate and generate. A second-level lookahead unit turns the four slice propagate and generate pairs, plus the carry input, into the carry that enters each slice and the final carry-out. Each sum bit is the XOR of the two operand bits and the carry that reaches that bit.

The block also drives a block-wide propagate and generate pair, so that a lookahead unit one level higher can combine several of these adders. A build parameter picks a chained variant. In that variant each slice's own carry-out feeds the next slice, and the second-level unit is kept only to form the exported pair. Both variants give the same sum and carry-out for every input.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `opa + opb + cin`.
- R2: `cout` equals bit 16 of `opa + opb + cin`.
- R3: `blk_prop` is 1 exactly when every bit position has `opa[i] OR opb[i]` equal to 1.
- R4: `blk_gen` is 1 exactly when `opa + opb` with a zero carry input produces a carry out of bit 15, whatever the value of `cin`.
- R5: `cout` equals `blk_gen OR (blk_prop AND cin)`.
- R6: With `USE_RIPPLE = 1`, the slices are chained. `sum`, `cout`, `blk_prop` and `blk_gen` then equal those of the default lookahead build for the same inputs.
- R7: A carry made in any slice reaches every higher slice. For example, `0xFFFF + 0x0000` with `cin = 1` gives `sum = 0x0000` and `cout = 1`, and `0x000F + 0x0001` gives `sum = 0x0010`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Block-wide propagate, for a higher lookahead level |
| blk_gen | output | 1 | Block-wide generate, for a higher lookahead level |

## Verification
Every output is purely combinational, so each result is due in the same clock cycle as the stimulus, with zero register stages. The driver applies a vector just after a rising edge and queues the values expected from plain integer addition. The monitor pops that entry at the following falling edge, half a period later, when the inputs have been stable for a while. It compares both the lookahead build and the chained build against the entry.

// File: rtl/cla_pkg.sv
// Package: shared sizes and the lookahead carry function.
// Assumes no operand slice handed to cla_carry is wider than LA_MAX.
package cla_pkg;
    localparam int LA_MAX = 32;

    // Carry out of position 'upto' in expanded sum-of-products form:
    // OR over j of (g[j] AND p[j+1..upto]), OR (cin AND p[0..upto]).
    function automatic logic cla_carry(input logic [LA_MAX-1:0] g,
                                       input logic [LA_MAX-1:0] p,
                                       input logic              cin,
                                       input int                upto);
        logic carry;
        logic term;
        carry = 1'b0;
        for (int j = 0; j <= upto; j++) begin
            term = g[j];
            for (int k = j + 1; k <= upto; k++) term = term & p[k];
            carry = carry | term;
        end
        term = cin;
        for (int k = 0; k <= upto; k++) term = term & p[k];
        return carry | term;
    endfunction
endpackage

// File: rtl/cla_group.sv
// Module: one carry-lookahead slice of GW bits.
// It forms the bit generate and propagate terms and the carries inside the
// slice, which depend only on those terms and cin. It also drives the slice
// sum, the slice propagate and generate, and its own carry-out.
// Assumes GW <= cla_pkg::LA_MAX.
module cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          gp,
    output logic          gg,
    output logic          co
);
    import cla_pkg::*;

    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;
    logic [GW:0]       c;

    // Bit terms, zero-extended for the shared lookahead function.
    always_comb begin
        g_ext = '0;
        p_ext = '0;
        g_ext[GW-1:0] = a & b;
        p_ext[GW-1:0] = a | b;
    end

    // Carries inside the slice, each written as a lookahead expression.
    always_comb begin
        c[0] = cin;
        for (int i = 0; i < GW; i++) c[i+1] = cla_carry(g_ext, p_ext, cin, i);
    end

    // Sum bits use the carry delivered to each position.
    always_comb s = a ^ b ^ c[GW-1:0];

    // Slice propagate and generate, for the second level.
    always_comb begin
        gp = &p_ext[GW-1:0];
        gg = cla_carry(g_ext, p_ext, 1'b0, GW - 1);
    end

    always_comb co = c[GW];

    // R4: a slice that generates must produce a carry-out for any cin.
    always_comb begin
        a_r4_grp_gen_implies_co: assert (!(gg && !co))
            else $error("slice generate set but carry-out clear");
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module: second-level lookahead unit.
// From NG slice propagate and generate pairs and the block carry input,
// it drives the carry into every slice, the block carry-out, and the
// block-wide propagate and generate pair.
// Assumes NG <= cla_pkg::LA_MAX.
module cla_lookahead #(
    parameter int NG = 4
) (
    input  logic [NG-1:0] gp,
    input  logic [NG-1:0] gg,
    input  logic          c0,
    output logic [NG:0]   cg,
    output logic          bp,
    output logic          bg
);
    import cla_pkg::*;

    logic [LA_MAX-1:0] gg_ext;
    logic [LA_MAX-1:0] gp_ext;

    // Widen the slice terms for the shared function.
    always_comb begin
        gg_ext = '0;
        gp_ext = '0;
        gg_ext[NG-1:0] = gg;
        gp_ext[NG-1:0] = gp;
    end

    // Carries between slices: C(k+1) from G/P of slices 0..k and c0.
    always_comb begin
        cg[0] = c0;
        for (int k = 0; k < NG; k++) cg[k+1] = cla_carry(gg_ext, gp_ext, c0, k);
    end

    // Block pair exported to a higher lookahead level.
    always_comb begin
        bp = &gp;
        bg = cla_carry(gg_ext, gp_ext, 1'b0, NG - 1);
    end
endmodule

// File: rtl/cla16_adder.sv
// Module: two-level carry-lookahead adder (top).
// WIDTH bits are split into WIDTH/GW slices. With USE_RIPPLE = 0 the
// second-level unit feeds every slice carry. With USE_RIPPLE = 1 each slice
// takes the carry-out of the slice below, and the second-level unit only
// forms the exported block pair. Assumes WIDTH is a multiple of GW.
module cla16_adder #(
    parameter int WIDTH      = 16,
    parameter int GW         = 4,
    parameter bit USE_RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             blk_prop,
    output logic             blk_gen
);
    localparam int NG = WIDTH / GW;

    logic [NG-1:0] s_prop;
    logic [NG-1:0] s_gen;
    logic [NG-1:0] s_co;
    logic [NG:0]   la_c;
    logic [NG-1:0] s_cin;

    // Second-level unit: always present for the exported pair.
    cla_lookahead #(.NG(NG)) u_la (
        .gp (s_prop),
        .gg (s_gen),
        .c0 (cin),
        .cg (la_c),
        .bp (blk_prop),
        .bg (blk_gen)
    );

    // Slices, with their carry source chosen by the variant.
    for (genvar k = 0; k < NG; k++) begin : g_slice
        if (USE_RIPPLE) begin : g_rip
            if (k == 0) begin : g_first
                always_comb s_cin[k] = cin;
            end else begin : g_next
                always_comb s_cin[k] = s_co[k-1];
            end
        end else begin : g_la
            always_comb s_cin[k] = la_c[k];
            // R7: the lookahead carry into slice k+1 equals the carry the
            // slice itself computes.
            always_comb begin
                a_r7_carry_agree: assert (la_c[k+1] == s_co[k])
                    else $error("lookahead carry %0d disagrees with slice", k + 1);
            end
        end

        cla_group #(.GW(GW)) u_grp (
            .a   (opa[k*GW +: GW]),
            .b   (opb[k*GW +: GW]),
            .cin (s_cin[k]),
            .s   (sum[k*GW +: GW]),
            .gp  (s_prop[k]),
            .gg  (s_gen[k]),
            .co  (s_co[k])
        );
    end

    // Carry-out from the lookahead unit or from the last slice.
    if (USE_RIPPLE) begin : g_co_rip
        always_comb cout = s_co[NG-1];
    end else begin : g_co_la
        always_comb cout = la_c[NG];
    end

    // R1, R2: the whole result matches integer addition.
    always_comb begin
        a_r1_sum_matches: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin}))
            else $error("sum/carry differ from integer addition");
    end

    // R5: the carry-out agrees with the exported block pair.
    always_comb begin
        a_r5_cout_form: assert (cout == (blk_gen | (blk_prop & cin)))
            else $error("carry-out disagrees with block propagate/generate");
    end
endmodule

// File: tb/test_cla16_adder.sv
// Bench: scoreboard for both variants. The driver queues expected items,
// and the monitor pops and compares them at the falling edge.
module test_cla16_adder;
    typedef struct packed {
        logic [15:0] s;
        logic        co;
        logic        p;
        logic        g;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        cin = 1'b0;
    logic [15:0] sum_la, sum_rp;
    logic        co_la, co_rp, p_la, p_rp, g_la, g_rp;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    cla16_adder i_cla16_adder (
        .opa(opa), .opb(opb), .cin(cin), .sum(sum_la), .cout(co_la),
        .blk_prop(p_la), .blk_gen(g_la)
    );

    cla16_adder #(.USE_RIPPLE(1'b1)) i_cla16_adder_rip (
        .opa(opa), .opb(opb), .cin(cin), .sum(sum_rp), .cout(co_rp),
        .blk_prop(p_rp), .blk_gen(g_rp)
    );

    // Count one comparison and report it when it fails.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, opa, opb, cin);
        end
    endtask

    // Driver: apply a vector and queue results computed by integer addition.
    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c);
        exp_t e;
        logic [16:0] full;
        logic [16:0] nocarry;
        @(posedge clk);
        opa = a; opb = b; cin = c;
        full    = {1'b0, a} + {1'b0, b} + {16'd0, c};
        nocarry = {1'b0, a} + {1'b0, b};
        e.s  = full[15:0];
        e.co = full[16];
        e.p  = &(a | b);
        e.g  = nocarry[16];
        sb_q.push_back(e);
    endtask

    // Monitor: results are combinational, due half a period after driving.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R1 sum",            {16'd0, sum_la}, {16'd0, e.s});
                check("R2 cout",           {31'd0, co_la},  {31'd0, e.co});
                check("R3 blk_prop",       {31'd0, p_la},   {31'd0, e.p});
                check("R4 blk_gen",        {31'd0, g_la},   {31'd0, e.g});
                check("R5 cout form",      {31'd0, co_la},  {31'd0, e.g | (e.p & cin)});
                check("R6 ripple sum",     {16'd0, sum_rp}, {16'd0, sum_la});
                check("R6 ripple cout",    {31'd0, co_rp},  {31'd0, co_la});
                check("R6 ripple pg",      {30'd0, p_rp, g_rp}, {30'd0, p_la, g_la});
            end
        end
    end

    initial begin
        // Reset state: zero inputs give all-zero outputs.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset sum", {16'd0, sum_la}, 32'd0);
        check("R2 reset cout", {31'd0, co_la}, 32'd0);
        rst_n = 1'b1;

        // R7: carries crossing slice boundaries.
        drive(16'hFFFF, 16'h0000, 1'b1);
        drive(16'h000F, 16'h0001, 1'b0);
        drive(16'h00FF, 16'h0001, 1'b0);
        drive(16'h0FFF, 16'h0000, 1'b1);
        drive(16'hFFFF, 16'hFFFF, 1'b1);
        drive(16'h8000, 16'h8000, 1'b0);
        // R3/R4: propagate-only and generate corners.
        drive(16'hAAAA, 16'h5555, 1'b0);
        drive(16'hAAAA, 16'h5555, 1'b1);
        drive(16'h0000, 16'h0000, 1'b1);
        drive(16'h7FFF, 16'h0001, 1'b0);
        drive(16'h1234, 16'hEDCB, 1'b1);
        // Walking ones across every bit position.
        for (int i = 0; i < 16; i++) drive(16'(1 << i), 16'(16'hFFFF >> (15 - i)), 1'(i % 2));
        // Random vectors.
        for (int i = 0; i < 400; i++) drive(16'($urandom), 16'($urandom), 1'($urandom));

        wait (sb_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule